// File: doc/BRIEF.md
# Radio Operating-Mode Strobe Controller

This block holds the operating mode of a packet radio's digital core. An SPI front end decodes single-byte command strobes and hands each one over as a 6-bit code qualified by a one-cycle valid pulse. It also reports chip-select edges as one-cycle events. From these inputs, and from overflow events raised by the FIFO logic, the block moves between eight modes: idle, calibrating, receive, transmit, receive-overflow, transmit-overflow, sleep and waking.

Whether a strobe is obeyed depends on the current mode. Receive and transmit need a completed frequency calibration. FIFO flushes are obeyed only in idle or in the matching overflow mode. Power-down is only armed by its strobe and takes effect when chip select is released. Calibration and the wake-up delay are modelled as parameterised cycle counts. Every strobe code in the strobe range returns a 4-bit status nibble that captures the mode and the calibration flag as they were when the strobe arrived.

Top module: `radio_mode_ctrl`

## Requirements
- R1: After reset the mode output is idle (code 0), `calibrated` is 0, and `flushRx`, `flushTx` and `statusValid` are 0.
- R2: A valid strobe with code 0x30 to 0x3D raises `statusValid` for one cycle, in the cycle after the strobe. `statusNibble` is then {calibrated, mode[2:0]} as they stood in the strobe's cycle. The mode codes are idle 0, rx 1, tx 2, calibrating 3, rx-overflow 4, tx-overflow 5, sleep 6, waking 7. Codes outside 0x30 to 0x3D give no status.
- R3: Calibrate (0x33) in idle enters calibrating for exactly CAL_CYCLES cycles, then returns to idle with `calibrated` set. In any other mode it is ignored.
- R4: Enter-rx (0x34) and enter-tx (0x35) move idle to rx or tx only while `calibrated` is 1. Otherwise they are ignored.
- R5: Go-idle (0x36) moves rx, tx, rx-overflow or tx-overflow to idle.
- R6: `rxOvfEvt` moves rx to rx-overflow, and `txOvfEvt` moves tx to tx-overflow. In other modes each event has no effect.
- R7: Flush-rx (0x3A) pulses `flushRx` for one cycle, in the cycle after the strobe, but only in idle or rx-overflow. Rx-overflow then goes to idle. Flush-tx (0x3B) does the same with `flushTx` in idle or tx-overflow. In every other mode both are ignored.
- R8: Power-down (0x39) leaves the mode unchanged and arms a pending flag. The next `csRise` in idle, rx, tx or an overflow mode then enters sleep. A `csRise` with nothing armed has no effect.
- R9: In sleep, `csFall` enters waking. Waking lasts WAKE_US*CYCLES_PER_US cycles and then returns to idle. `calibrated` is kept through sleep, and strobes other than reset are ignored in sleep.
- R10: In calibrating and waking, every strobe except reset is ignored.
- R11: Reset (0x30) in any mode goes to idle, clears `calibrated` and the pending power-down, and pulses `flushRx` and `flushTx` together in the next cycle.
- R12: Status-only (0x3D) and undefined codes in 0x30 to 0x3D change no mode and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| strobeValid | input | 1 | Qualifies strobeCode for one cycle |
| strobeCode | input | 6 | Decoded strobe code |
| csRise | input | 1 | One-cycle event: chip select released |
| csFall | input | 1 | One-cycle event: chip select asserted (wakes from sleep) |
| rxOvfEvt | input | 1 | Receive FIFO overflow event |
| txOvfEvt | input | 1 | Transmit FIFO underflow/overflow event |
| modeState | output | 3 | Current mode code |
| calibrated | output | 1 | A calibration has completed since the last reset strobe |
| flushRx | output | 1 | One-cycle receive FIFO flush pulse |
| flushTx | output | 1 | One-cycle transmit FIFO flush pulse |
| statusValid | output | 1 | Status nibble valid |
| statusNibble | output | 4 | {calibrated, mode} as seen by the strobe |

## Verification
The bench targets the legality rules that are easy to get almost right. A flush sent to the opposite overflow mode must not flush, or it would discard live data. Receive and transmit must not start before calibration, or the radio would run on an unlocked synthesizer. A strobe sent during calibration or wake-up must not cut the delay short. The bench also measures the calibration and wake-up windows to the cycle, so an off-by-one counter shows up as a mode change one cycle early or late. It checks that a power-down strobe enters sleep only on a later chip-select release, and that a reset strobe cancels an armed power-down. A design that captured status after the mode update would return the new mode instead of the old one, and the status checks catch that.

// File: rtl/radio_mode_pkg.sv
`timescale 1ns/1ps
package radio_mode_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE   = 3'd0,
    MODE_RX     = 3'd1,
    MODE_TX     = 3'd2,
    MODE_CALIB  = 3'd3,
    MODE_RX_OVF = 3'd4,
    MODE_TX_OVF = 3'd5,
    MODE_SLEEP  = 3'd6,
    MODE_WAKE   = 3'd7
  } mode_e;

  localparam int CODE_W = 6;

  localparam logic [CODE_W-1:0] STB_RESET    = 6'h30;
  localparam logic [CODE_W-1:0] STB_CAL      = 6'h33;
  localparam logic [CODE_W-1:0] STB_RX       = 6'h34;
  localparam logic [CODE_W-1:0] STB_TX       = 6'h35;
  localparam logic [CODE_W-1:0] STB_IDLE     = 6'h36;
  localparam logic [CODE_W-1:0] STB_PWRDN    = 6'h39;
  localparam logic [CODE_W-1:0] STB_FLUSH_RX = 6'h3A;
  localparam logic [CODE_W-1:0] STB_FLUSH_TX = 6'h3B;
  localparam logic [CODE_W-1:0] STB_NOP      = 6'h3D;
  localparam logic [CODE_W-1:0] STB_FIRST    = 6'h30;
  localparam logic [CODE_W-1:0] STB_LAST     = 6'h3D;

  // control -> datapath strobes
  typedef struct packed {
    logic timerLoad;
    logic timerWake;
    logic calSet;
    logic calClr;
    logic sleepArm;
    logic sleepClr;
    logic flushRx;
    logic flushTx;
    logic statusLoad;
  } ctrl_cmd_t;

endpackage

// File: rtl/radio_mode_fsm.sv
`timescale 1ns/1ps
module radio_mode_fsm
  import radio_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              strobeValid,
  input  logic [CODE_W-1:0] strobeCode,
  input  logic              csRise,
  input  logic              csFall,
  input  logic              rxOvfEvt,
  input  logic              txOvfEvt,
  input  logic              calibrated,
  input  logic              sleepPending,
  input  logic              timerZero,
  output mode_e             modeQ,
  output ctrl_cmd_t         cmd
);

  mode_e modeD;
  logic  isStrobe;
  logic  isReset;

  assign isStrobe = strobeValid && (strobeCode >= STB_FIRST) && (strobeCode <= STB_LAST);
  assign isReset  = isStrobe && (strobeCode == STB_RESET);

  always_comb begin
    modeD          = modeQ;
    cmd            = '0;
    cmd.statusLoad = isStrobe;
    if (isReset) begin
      modeD        = MODE_IDLE;
      cmd.calClr   = 1'b1;
      cmd.sleepClr = 1'b1;
      cmd.flushRx  = 1'b1;
      cmd.flushTx  = 1'b1;
    end else begin
      case (modeQ)
        MODE_CALIB: begin
          if (timerZero) begin
            modeD      = MODE_IDLE;
            cmd.calSet = 1'b1;
          end
        end
        MODE_WAKE: begin
          if (timerZero) modeD = MODE_IDLE;
        end
        MODE_SLEEP: begin
          if (csFall) begin
            modeD         = MODE_WAKE;
            cmd.timerLoad = 1'b1;
            cmd.timerWake = 1'b1;
          end
        end
        default: begin
          if (csRise && sleepPending) begin
            modeD        = MODE_SLEEP;
            cmd.sleepClr = 1'b1;
          end else if (isStrobe) begin
            case (strobeCode)
              STB_CAL: begin
                if (modeQ == MODE_IDLE) begin
                  modeD         = MODE_CALIB;
                  cmd.timerLoad = 1'b1;
                end
              end
              STB_RX: begin
                if (modeQ == MODE_IDLE && calibrated) modeD = MODE_RX;
              end
              STB_TX: begin
                if (modeQ == MODE_IDLE && calibrated) modeD = MODE_TX;
              end
              STB_IDLE: modeD = MODE_IDLE;
              STB_PWRDN: cmd.sleepArm = 1'b1;
              STB_FLUSH_RX: begin
                if (modeQ == MODE_IDLE || modeQ == MODE_RX_OVF) begin
                  cmd.flushRx = 1'b1;
                  modeD       = MODE_IDLE;
                end
              end
              STB_FLUSH_TX: begin
                if (modeQ == MODE_IDLE || modeQ == MODE_TX_OVF) begin
                  cmd.flushTx = 1'b1;
                  modeD       = MODE_IDLE;
                end
              end
              default: ;
            endcase
          end else if (modeQ == MODE_RX && rxOvfEvt) begin
            modeD = MODE_RX_OVF;
          end else if (modeQ == MODE_TX && txOvfEvt) begin
            modeD = MODE_TX_OVF;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= MODE_IDLE;
    else       modeQ <= modeD;
  end

endmodule

// File: rtl/radio_mode_dp.sv
`timescale 1ns/1ps
module radio_mode_dp
  import radio_mode_pkg::*;
#(
  parameter int CAL_CYCLES  = 16,
  parameter int WAKE_CYCLES = 150
) (
  input  logic      clk,
  input  logic      rstN,
  input  ctrl_cmd_t cmd,
  input  mode_e     modeQ,
  output logic      calibrated,
  output logic      sleepPending,
  output logic      timerZero,
  output logic      flushRx,
  output logic      flushTx,
  output logic      statusValid,
  output logic [3:0] statusNibble
);

  localparam int MAX_CYCLES = (CAL_CYCLES > WAKE_CYCLES) ? CAL_CYCLES : WAKE_CYCLES;
  localparam int TIMER_W    = $clog2(MAX_CYCLES + 1);
  localparam logic [TIMER_W-1:0] CAL_LOAD  = TIMER_W'(CAL_CYCLES - 1);
  localparam logic [TIMER_W-1:0] WAKE_LOAD = TIMER_W'(WAKE_CYCLES - 1);

  logic [TIMER_W-1:0] timerQ;

  assign timerZero = (timerQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN)              timerQ <= '0;
    else if (cmd.timerLoad) timerQ <= cmd.timerWake ? WAKE_LOAD : CAL_LOAD;
    else if (!timerZero)    timerQ <= timerQ - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           calibrated <= 1'b0;
    else if (cmd.calClr) calibrated <= 1'b0;
    else if (cmd.calSet) calibrated <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             sleepPending <= 1'b0;
    else if (cmd.sleepClr) sleepPending <= 1'b0;
    else if (cmd.sleepArm) sleepPending <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flushRx      <= 1'b0;
      flushTx      <= 1'b0;
      statusValid  <= 1'b0;
      statusNibble <= '0;
    end else begin
      flushRx     <= cmd.flushRx;
      flushTx     <= cmd.flushTx;
      statusValid <= cmd.statusLoad;
      if (cmd.statusLoad) statusNibble <= {calibrated, modeQ};
    end
  end

endmodule

// File: rtl/radio_mode_ctrl.sv
`timescale 1ns/1ps
module radio_mode_ctrl
  import radio_mode_pkg::*;
#(
  parameter int CAL_CYCLES    = 16,
  parameter int WAKE_US       = 150,
  parameter int CYCLES_PER_US = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       strobeValid,
  input  logic [5:0] strobeCode,
  input  logic       csRise,
  input  logic       csFall,
  input  logic       rxOvfEvt,
  input  logic       txOvfEvt,
  output logic [2:0] modeState,
  output logic       calibrated,
  output logic       flushRx,
  output logic       flushTx,
  output logic       statusValid,
  output logic [3:0] statusNibble
);

  localparam int WAKE_CYCLES = WAKE_US * CYCLES_PER_US;

  mode_e     modeQ;
  ctrl_cmd_t cmd;
  logic      sleepPending;
  logic      timerZero;

  radio_mode_fsm u_fsm (
    .clk          (clk),
    .rstN         (rstN),
    .strobeValid  (strobeValid),
    .strobeCode   (strobeCode),
    .csRise       (csRise),
    .csFall       (csFall),
    .rxOvfEvt     (rxOvfEvt),
    .txOvfEvt     (txOvfEvt),
    .calibrated   (calibrated),
    .sleepPending (sleepPending),
    .timerZero    (timerZero),
    .modeQ        (modeQ),
    .cmd          (cmd)
  );

  radio_mode_dp #(
    .CAL_CYCLES  (CAL_CYCLES),
    .WAKE_CYCLES (WAKE_CYCLES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .cmd          (cmd),
    .modeQ        (modeQ),
    .calibrated   (calibrated),
    .sleepPending (sleepPending),
    .timerZero    (timerZero),
    .flushRx      (flushRx),
    .flushTx      (flushTx),
    .statusValid  (statusValid),
    .statusNibble (statusNibble)
  );

  assign modeState = modeQ;

endmodule

// File: rtl/radio_mode_ctrl_chk.sv
`timescale 1ns/1ps
module radio_mode_ctrl_chk #(
  parameter int CAL_CYCLES = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic       strobeValid,
  input logic [5:0] strobeCode,
  input logic       csRise,
  input logic [2:0] modeState,
  input logic       calibrated,
  input logic       flushRx,
  input logic       flushTx,
  input logic       statusValid
);

  int calRun;

  always_ff @(posedge clk) begin
    if (!rstN)                  calRun <= 0;
    else if (modeState == 3'd3) calRun <= calRun + 1;
    else                        calRun <= 0;
  end

  // R11
  reset_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobeValid && strobeCode == 6'h30) |=> (modeState == 3'd0 && !calibrated && flushRx && flushTx));

  // R4
  trx_needs_cal_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((modeState == 3'd1 || modeState == 3'd2) && $past(modeState) != modeState) |-> $past(calibrated));

  // R8
  sleep_on_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeState == 3'd6 && $past(modeState) != 3'd6) |-> $past(csRise));

  // R7
  flush_rx_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushRx |-> ($past(modeState) == 3'd0 || $past(modeState) == 3'd4 ||
                 ($past(strobeValid) && $past(strobeCode) == 6'h30)));

  // R7
  flush_tx_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushTx |-> ($past(modeState) == 3'd0 || $past(modeState) == 3'd5 ||
                 ($past(strobeValid) && $past(strobeCode) == 6'h30)));

  // R2
  status_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |-> $past(strobeValid));

  // R3
  cal_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    calRun <= CAL_CYCLES);

endmodule

bind radio_mode_ctrl radio_mode_ctrl_chk #(.CAL_CYCLES(CAL_CYCLES)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .strobeValid (strobeValid),
  .strobeCode  (strobeCode),
  .csRise      (csRise),
  .modeState   (modeState),
  .calibrated  (calibrated),
  .flushRx     (flushRx),
  .flushTx     (flushTx),
  .statusValid (statusValid)
);

// File: tb/test_radio_mode_ctrl.sv
`timescale 1ns/1ps
module test_radio_mode_ctrl;

  localparam int CAL  = 8;
  localparam int WUS  = 2;
  localparam int CPU  = 5;
  localparam int WAKE = WUS * CPU;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       strobeValid = 1'b0;
  logic [5:0] strobeCode = '0;
  logic       csRise = 1'b0;
  logic       csFall = 1'b0;
  logic       rxOvfEvt = 1'b0;
  logic       txOvfEvt = 1'b0;
  logic [2:0] modeState;
  logic       calibrated;
  logic       flushRx;
  logic       flushTx;
  logic       statusValid;
  logic [3:0] statusNibble;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 0;

  always #4 clk = ~clk;

  radio_mode_ctrl #(
    .CAL_CYCLES    (CAL),
    .WAKE_US       (WUS),
    .CYCLES_PER_US (CPU)
  ) i_radio_mode_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .strobeValid  (strobeValid),
    .strobeCode   (strobeCode),
    .csRise       (csRise),
    .csFall       (csFall),
    .rxOvfEvt     (rxOvfEvt),
    .txOvfEvt     (txOvfEvt),
    .modeState    (modeState),
    .calibrated   (calibrated),
    .flushRx      (flushRx),
    .flushTx      (flushTx),
    .statusValid  (statusValid),
    .statusNibble (statusNibble)
  );

  // code, expMode, expFlushRx, expFlushTx, expStatusValid, expStatus, gap
  localparam int NVEC = 19;
  localparam logic [23:0] VEC [NVEC] = '{
    {6'h34, 3'd0, 1'b0, 1'b0, 1'b1, 4'h0, 8'd0},
    {6'h35, 3'd0, 1'b0, 1'b0, 1'b1, 4'h0, 8'd0},
    {6'h3D, 3'd0, 1'b0, 1'b0, 1'b1, 4'h0, 8'd0},
    {6'h3A, 3'd0, 1'b1, 1'b0, 1'b1, 4'h0, 8'd0},
    {6'h3B, 3'd0, 1'b0, 1'b1, 1'b1, 4'h0, 8'd0},
    {6'h33, 3'd3, 1'b0, 1'b0, 1'b1, 4'h0, 8'(CAL)},
    {6'h34, 3'd1, 1'b0, 1'b0, 1'b1, 4'h8, 8'd0},
    {6'h3A, 3'd1, 1'b0, 1'b0, 1'b1, 4'h9, 8'd0},
    {6'h33, 3'd1, 1'b0, 1'b0, 1'b1, 4'h9, 8'd0},
    {6'h36, 3'd0, 1'b0, 1'b0, 1'b1, 4'h9, 8'd0},
    {6'h35, 3'd2, 1'b0, 1'b0, 1'b1, 4'h8, 8'd0},
    {6'h3B, 3'd2, 1'b0, 1'b0, 1'b1, 4'hA, 8'd0},
    {6'h34, 3'd2, 1'b0, 1'b0, 1'b1, 4'hA, 8'd0},
    {6'h36, 3'd0, 1'b0, 1'b0, 1'b1, 4'hA, 8'd0},
    {6'h37, 3'd0, 1'b0, 1'b0, 1'b1, 4'h8, 8'd0},
    {6'h31, 3'd0, 1'b0, 1'b0, 1'b1, 4'h8, 8'd0},
    {6'h3E, 3'd0, 1'b0, 1'b0, 1'b0, 4'h0, 8'd0},
    {6'h30, 3'd0, 1'b1, 1'b1, 1'b1, 4'h8, 8'd0},
    {6'h34, 3'd0, 1'b0, 1'b0, 1'b1, 4'h0, 8'd0}
  };

  function automatic string reqOf(input logic [5:0] c);
    case (c)
      6'h30:        return "R11";
      6'h33:        return "R3";
      6'h34, 6'h35: return "R4";
      6'h36:        return "R5";
      6'h3A, 6'h3B: return "R7";
      6'h39:        return "R8";
      default:      return "R12";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic strobe(input logic [5:0] c);
    @(negedge clk);
    strobeValid = 1'b1;
    strobeCode  = c;
    @(negedge clk);
    strobeValid = 1'b0;
    strobeCode  = '0;
  endtask

  task automatic pulseCsRise();
    @(negedge clk); csRise = 1'b1;
    @(negedge clk); csRise = 1'b0;
  endtask

  task automatic pulseCsFall();
    @(negedge clk); csFall = 1'b1;
    @(negedge clk); csFall = 1'b0;
  endtask

  task automatic pulseRxOvf();
    @(negedge clk); rxOvfEvt = 1'b1;
    @(negedge clk); rxOvfEvt = 1'b0;
  endtask

  task automatic pulseTxOvf();
    @(negedge clk); txOvfEvt = 1'b1;
    @(negedge clk); txOvfEvt = 1'b0;
  endtask

  task automatic calibrateNow();
    strobe(6'h33);
    repeat (CAL) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "mode", modeState, 0);
    check("R1", "calibrated", calibrated, 0);
    check("R1", "flushes", {flushRx, flushTx}, 0);
    check("R1", "statusValid", statusValid, 0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      logic [23:0] v;
      v = VEC[i];
      strobe(v[23:18]);
      check(reqOf(v[23:18]), "mode", modeState, v[17:15]);
      check(reqOf(v[23:18]), "flushRx/flushTx", {flushRx, flushTx}, v[14:13]);
      check("R2", "statusValid", statusValid, v[12]);
      if (v[12]) check("R2", "statusNibble", statusNibble, v[11:8]);
      repeat (v[7:0]) @(negedge clk);
    end

    // R3 calibration window length
    strobe(6'h33);
    check("R3", "mode calibrating", modeState, 3);
    repeat (CAL - 1) @(negedge clk);
    check("R3", "still calibrating at last cycle", modeState, 3);
    @(negedge clk);
    check("R3", "idle after window", modeState, 0);
    check("R3", "calibrated set", calibrated, 1);

    // R10 strobes in calibrating ignored, reset honoured
    strobe(6'h33);
    strobe(6'h36);
    check("R10", "go-idle ignored in calibrating", modeState, 3);
    check("R2", "status in calibrating", statusNibble, 4'hB);
    strobe(6'h30);
    check("R11", "reset in calibrating", modeState, 0);
    check("R11", "reset clears calibrated", calibrated, 0);
    calibrateNow();

    // R6 / R7 overflow handling
    strobe(6'h34);
    pulseRxOvf();
    check("R6", "rx overflow", modeState, 4);
    strobe(6'h3B);
    check("R7", "flush-tx ignored in rx-ovf mode", modeState, 4);
    check("R7", "flush-tx ignored in rx-ovf pulse", flushTx, 0);
    strobe(6'h34);
    check("R4", "rx ignored in rx-ovf", modeState, 4);
    strobe(6'h3A);
    check("R7", "flush-rx from rx-ovf mode", modeState, 0);
    check("R7", "flush-rx from rx-ovf pulse", flushRx, 1);
    check("R2", "status rx-ovf", statusNibble, 4'hC);
    @(negedge clk);
    check("R7", "flush-rx one cycle", flushRx, 0);

    strobe(6'h35);
    pulseRxOvf();
    check("R6", "rx event ignored in tx", modeState, 2);
    pulseTxOvf();
    check("R6", "tx overflow", modeState, 5);
    strobe(6'h3A);
    check("R7", "flush-rx ignored in tx-ovf", {modeState, flushRx}, {3'd5, 1'b0});
    strobe(6'h3B);
    check("R7", "flush-tx from tx-ovf", {modeState, flushTx}, {3'd0, 1'b1});
    check("R2", "status tx-ovf", statusNibble, 4'hD);

    strobe(6'h34);
    pulseRxOvf();
    strobe(6'h36);
    check("R5", "go-idle from rx-ovf", modeState, 0);

    // R8 deferred power-down
    pulseCsRise();
    check("R8", "csRise without pending", modeState, 0);
    strobe(6'h39);
    check("R8", "power-down does not sleep at once", modeState, 0);
    pulseCsRise();
    check("R8", "sleep on csRise", modeState, 6);

    // R9 sleep and wake
    strobe(6'h34);
    check("R9", "rx ignored in sleep", modeState, 6);
    check("R2", "status in sleep", statusNibble, 4'hE);
    @(negedge clk); csFall = 1'b1;
    @(negedge clk); csFall = 1'b0;
    check("R9", "waking", modeState, 7);
    strobe(6'h33);
    check("R10", "calibrate ignored in waking", modeState, 7);
    repeat (WAKE - 3) @(negedge clk);
    check("R9", "still waking at last cycle", modeState, 7);
    @(negedge clk);
    check("R9", "idle after wake", modeState, 0);
    check("R9", "calibrated kept", calibrated, 1);

    // R8 pending survives into rx, R11 reset in sleep
    strobe(6'h39);
    strobe(6'h34);
    check("R8", "rx after arming", modeState, 1);
    pulseCsRise();
    check("R8", "sleep from rx", modeState, 6);
    strobe(6'h30);
    check("R11", "reset in sleep", {modeState, calibrated, flushRx, flushTx}, {3'd0, 1'b0, 1'b1, 1'b1});

    // R11 reset cancels pending power-down
    strobe(6'h39);
    strobe(6'h30);
    pulseCsRise();
    check("R11", "pending cleared by reset", modeState, 0);

    // R12 status-only leaves rx untouched
    calibrateNow();
    strobe(6'h34);
    strobe(6'h3D);
    check("R12", "nop in rx", {modeState, calibrated}, {3'd1, 1'b1});

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule